// File: doc/BRIEF.md
# Chip-Select Bus Termination Generator

This block compares every bus address against a small set of programmable chip-select channels. It drives a chip-select line for each channel that the address hits, and it terminates the access with a two-bit acknowledge after a programmed number of wait states. All channels share one wait-state counter. That counter is loaded from the channel that wins the access. A fast setting ends an external transfer in two clock cycles. A separate setting leaves termination to an outside device.

Every decision is taken on the rising edge of the system clock, so the acknowledge is always aligned to that clock. A channel is configured with a base address, a compare mask, an enable, a strobe select (address strobe or data strobe), a timing mode and a 4-bit acknowledge field. If two or more enabled channels hit the same address and their settings differ, the block raises a configuration error. Software is expected to keep such channels identical.

Top module: `csTermGen`

## Requirements
- R1: Channel i hits when it is enabled and `((addr ^ base) & mask) == 0`. A mask bit of 1 means that address bit is compared.
- R2: `chipSel[i]` follows the inputs combinationally. It is high while channel i hits, its mode bit is 0 and its selected strobe is high. A strobe-select bit of 0 selects `addrStrobe` and a bit of 1 selects `dataStrobe`.
- R3: A channel whose mode bit is 1 (synchronous) never drives its chip select and never starts a termination.
- R4: The start edge is the first rising edge at which some chip select is high. For an acknowledge field n from 0 to 13, `ackOut` is first seen high after the (n+2)-th rising edge, counting the start edge as the first.
- R5: An acknowledge field of 14 (fast) makes `ackOut` high after the start edge itself, so the transfer takes two cycles.
- R6: An acknowledge field of 15 never raises `ackOut`. The block waits until the strobe negates.
- R7: Once raised, `ackOut` stays high while the strobe latched at the start edge is high. It falls after the first rising edge at which that strobe is low.
- R8: `ackOut` is 2'b11 while acknowledging and 2'b00 otherwise. Reset clears it to 2'b00.
- R9: The single counter is loaded from the lowest-index selected channel. If the strobe drops before the count ends, the access is abandoned with no acknowledge, and the next access is timed afresh.
- R10: `cfgErr` is high, combinationally, while two or more enabled channels hit the address and differ in mode bit, strobe-select bit or acknowledge field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| addr | input | ADDR_W | Bus address |
| addrStrobe | input | 1 | Address strobe, active high |
| dataStrobe | input | 1 | Data strobe, active high |
| cfgEnable | input | NUM_CH | Per-channel enable |
| cfgBase | input | NUM_CH*ADDR_W | Per-channel base address, channel i in bits [i*ADDR_W +: ADDR_W] |
| cfgMask | input | NUM_CH*ADDR_W | Per-channel compare mask, same packing as cfgBase |
| cfgStrbDs | input | NUM_CH | Strobe select: 0 address strobe, 1 data strobe |
| cfgModeSync | input | NUM_CH | Timing mode: 0 asynchronous, 1 synchronous (never selected) |
| cfgAck | input | NUM_CH*4 | Acknowledge field: 0-13 wait states, 14 fast, 15 external |
| chipSel | output | NUM_CH | Chip-select lines, active high |
| ackOut | output | 2 | Encoded acknowledge pair |
| cfgErr | output | 1 | Matching channels disagree in configuration |

## Verification
Chip selects and the configuration error depend only on the inputs. The bench therefore checks them one time unit after it drives the inputs, and it drops the strobes again before the next rising edge so that no access starts. The acknowledge arrives n+2 rising edges after the start edge, or one edge after it in fast mode. The bench drives the strobes at a falling edge, counts rising edges, samples at each following falling edge and compares the count at which `ackOut` first reads 2'b11 with a latency computed from the field value. After the strobes are released, the acknowledge must read 2'b00 at the falling edge after the next rising edge.

// File: rtl/csTermPkg.sv
package csTermPkg;
  localparam int ACK_W = 4;
  localparam logic [ACK_W-1:0] ACK_FAST = 4'd14;
  localparam logic [ACK_W-1:0] ACK_NONE = 4'd15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ACK,
    ST_EXT
  } ctrlState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } cntCtrl_t;
endpackage

// File: rtl/csDatapath.sv
module csDatapath
  import csTermPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    addrStrobe,
  input  logic                    dataStrobe,
  input  logic [NUM_CH-1:0]       cfgEnable,
  input  logic [NUM_CH*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CH*ADDR_W-1:0] cfgMask,
  input  logic [NUM_CH-1:0]       cfgStrbDs,
  input  logic [NUM_CH-1:0]       cfgModeSync,
  input  logic [NUM_CH*ACK_W-1:0] cfgAck,
  input  cntCtrl_t                ctrl,
  output logic [NUM_CH-1:0]       chipSel,
  output logic                    anySel,
  output logic [ACK_W-1:0]        winAck,
  output logic                    cntZero,
  output logic                    strbActive,
  output logic                    cfgErr
);
  logic [NUM_CH-1:0] hit;
  logic              winDs;
  logic [ACK_W-1:0]  waitCnt;
  logic              latchedDs;

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic chStrobe;
    assign hit[i] = cfgEnable[i] &&
      (((addr ^ cfgBase[i*ADDR_W +: ADDR_W]) & cfgMask[i*ADDR_W +: ADDR_W]) == '0);
    assign chStrobe = cfgStrbDs[i] ? dataStrobe : addrStrobe;
    assign chipSel[i] = hit[i] && !cfgModeSync[i] && chStrobe;
  end

  assign anySel = |chipSel;

  // lowest selected index wins the shared counter
  always_comb begin
    winAck = '0;
    winDs  = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chipSel[i]) begin
        winAck = cfgAck[i*ACK_W +: ACK_W];
        winDs  = cfgStrbDs[i];
      end
    end
  end

  always_comb begin
    logic             found;
    logic             refMode;
    logic             refDs;
    logic [ACK_W-1:0] refAck;
    found   = 1'b0;
    refMode = 1'b0;
    refDs   = 1'b0;
    refAck  = '0;
    cfgErr  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i]) begin
        if (!found) begin
          refMode = cfgModeSync[i];
          refDs   = cfgStrbDs[i];
          refAck  = cfgAck[i*ACK_W +: ACK_W];
        end else if (refMode != cfgModeSync[i] || refDs != cfgStrbDs[i] ||
                     refAck != cfgAck[i*ACK_W +: ACK_W]) begin
          cfgErr = 1'b1;
        end
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt   <= '0;
      latchedDs <= 1'b0;
    end else if (ctrl.loadCnt) begin
      waitCnt   <= winAck;
      latchedDs <= winDs;
    end else if (ctrl.decCnt && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero    = (waitCnt == '0);
  assign strbActive = latchedDs ? dataStrobe : addrStrobe;
endmodule

// File: rtl/csControl.sv
module csControl
  import csTermPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             anySel,
  input  logic [ACK_W-1:0] winAck,
  input  logic             cntZero,
  input  logic             strbActive,
  output cntCtrl_t         ctrl,
  output logic [1:0]       ackOut
);
  ctrlState_t state, nextState;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (anySel) begin
          ctrl.loadCnt = 1'b1;
          if (winAck == ACK_NONE)      nextState = ST_EXT;
          else if (winAck == ACK_FAST) nextState = ST_ACK;
          else                         nextState = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (!strbActive)  nextState = ST_IDLE;
        else if (cntZero) nextState = ST_ACK;
        else              ctrl.decCnt = 1'b1;
      end
      ST_ACK, ST_EXT: begin
        if (!strbActive) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign ackOut = {2{state == ST_ACK}};
endmodule

// File: rtl/csTermGen.sv
module csTermGen
  import csTermPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     addrStrobe,
  input  logic                     dataStrobe,
  input  logic [NUM_CH-1:0]        cfgEnable,
  input  logic [NUM_CH*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CH*ADDR_W-1:0] cfgMask,
  input  logic [NUM_CH-1:0]        cfgStrbDs,
  input  logic [NUM_CH-1:0]        cfgModeSync,
  input  logic [NUM_CH*4-1:0]      cfgAck,
  output logic [NUM_CH-1:0]        chipSel,
  output logic [1:0]               ackOut,
  output logic                     cfgErr
);
  cntCtrl_t         ctrl;
  logic             anySel;
  logic [ACK_W-1:0] winAck;
  logic             cntZero;
  logic             strbActive;

  csDatapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .addr(addr),
    .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
    .cfgEnable(cfgEnable), .cfgBase(cfgBase), .cfgMask(cfgMask),
    .cfgStrbDs(cfgStrbDs), .cfgModeSync(cfgModeSync), .cfgAck(cfgAck),
    .ctrl(ctrl), .chipSel(chipSel), .anySel(anySel), .winAck(winAck),
    .cntZero(cntZero), .strbActive(strbActive), .cfgErr(cfgErr)
  );

  csControl ctl (
    .clk(clk), .rstN(rstN), .anySel(anySel), .winAck(winAck),
    .cntZero(cntZero), .strbActive(strbActive), .ctrl(ctrl), .ackOut(ackOut)
  );
endmodule

// File: rtl/csTermGen_chk.sv
module csTermGen_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrStrobe,
  input logic              dataStrobe,
  input logic [NUM_CH-1:0] cfgModeSync,
  input logic [NUM_CH-1:0] chipSel,
  input logic [1:0]        ackOut
);
  a_r8_ack_encoding: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut == 2'b00) || (ackOut == 2'b11));

  a_r4_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut[0]) |-> $past(addrStrobe || dataStrobe));

  a_r7_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut[0] && addrStrobe && dataStrobe) |=> ackOut[0]);

  a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut[0] && !addrStrobe && !dataStrobe) |=> !ackOut[0]);

  a_r2_select_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (|chipSel) |-> (addrStrobe || dataStrobe));

  for (genvar i = 0; i < NUM_CH; i++) begin : gSync
    a_r3_sync_never_selects: assert property (@(posedge clk) disable iff (!rstN)
      cfgModeSync[i] |-> !chipSel[i]);
  end
endmodule

bind csTermGen csTermGen_chk #(.NUM_CH(NUM_CH)) chkInst (
  .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
  .cfgModeSync(cfgModeSync), .chipSel(chipSel), .ackOut(ackOut)
);

// File: tb/csTermGen_test.sv
`timescale 1ns/1ps
module csTermGen_test;
  localparam int NCH = 4;
  localparam int AW  = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic              addrStrobe = 1'b0;
  logic              dataStrobe = 1'b0;
  logic [NCH-1:0]    cfgEnable = '0;
  logic [NCH*AW-1:0] cfgBase = '0;
  logic [NCH*AW-1:0] cfgMask = '0;
  logic [NCH-1:0]    cfgStrbDs = '0;
  logic [NCH-1:0]    cfgModeSync = '0;
  logic [NCH*4-1:0]  cfgAck = '0;
  logic [NCH-1:0]    chipSel;
  logic [1:0]        ackOut;
  logic              cfgErr;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  csTermGen #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .addrStrobe(addrStrobe),
    .dataStrobe(dataStrobe), .cfgEnable(cfgEnable), .cfgBase(cfgBase),
    .cfgMask(cfgMask), .cfgStrbDs(cfgStrbDs), .cfgModeSync(cfgModeSync),
    .cfgAck(cfgAck), .chipSel(chipSel), .ackOut(ackOut), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCh(input int i, input bit en, input logic [AW-1:0] base,
                       input logic [AW-1:0] mask, input bit ds, input bit sync,
                       input logic [3:0] ack);
    cfgEnable[i]           = en;
    cfgBase[i*AW +: AW]    = base;
    cfgMask[i*AW +: AW]    = mask;
    cfgStrbDs[i]           = ds;
    cfgModeSync[i]         = sync;
    cfgAck[i*4 +: 4]       = ack;
  endtask

  // combinational select probe that never crosses a rising edge
  task automatic probe(input logic [AW-1:0] a, input string req,
                       input int expCs, input int expErr);
    @(negedge clk);
    addr = a; addrStrobe = 1'b1; dataStrobe = 1'b1;
    #1;
    check(req, int'(chipSel), expCs);
    check("R10", int'(cfgErr), expErr);
    addrStrobe = 1'b0; dataStrobe = 1'b0;
  endtask

  // full access: returns the edge count at which ackOut first reads 2'b11 (0 = none)
  task automatic access(input logic [AW-1:0] a, input int expCs, input int expLat,
                        input string req);
    int lat;
    lat = 0;
    @(negedge clk);
    addr = a; addrStrobe = 1'b1; dataStrobe = 1'b1;
    #1;
    check({req, " chipSel"}, int'(chipSel), expCs);
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (ackOut == 2'b11) begin lat = k; break; end
      check("R8 idle ack", int'(ackOut), 0);
    end
    check({req, " latency"}, lat, expLat);
    if (lat != 0) begin
      for (int k = 0; k < 2; k++) begin
        @(posedge clk); @(negedge clk);
        check("R7 hold", int'(ackOut), 3);
      end
    end
    addrStrobe = 1'b0; dataStrobe = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 release", int'(ackOut), 0);
    @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset ack", int'(ackOut), 0);
    check("R2 reset chipSel", int'(chipSel), 0);
    rstN = 1'b1;

    // R4 R5 R6: sweep every acknowledge value with both strobe selects
    for (int ds = 0; ds < 2; ds++) begin
      for (int n = 0; n < 16; n++) begin
        int expLat;
        setCh(0, 1'b1, 24'h100000, 24'hFF0000, ds[0], 1'b0, n[3:0]);
        expLat = (n == 14) ? 1 : (n == 15) ? 0 : n + 2;
        access(24'h10ABCD, 1, expLat,
               (n == 14) ? "R5" : (n == 15) ? "R6" : "R4");
      end
    end

    // R1: mask compare
    setCh(0, 1'b0, 24'h0, 24'h0, 1'b0, 1'b0, 4'd0);
    setCh(1, 1'b1, 24'h200000, 24'hFFF000, 1'b0, 1'b0, 4'd3);
    setCh(2, 1'b1, 24'h300400, 24'hFFFFFF, 1'b0, 1'b0, 4'd3);
    probe(24'h200ABC, "R1", 2, 0);
    probe(24'h201000, "R1", 0, 0);
    probe(24'h300400, "R1", 4, 0);
    probe(24'h300401, "R1", 0, 0);
    setCh(1, 1'b0, 24'h200000, 24'hFFF000, 1'b0, 1'b0, 4'd3);
    probe(24'h200ABC, "R1 disabled", 0, 0);
    setCh(2, 1'b0, 24'h0, 24'h0, 1'b0, 1'b0, 4'd0);

    // R2: data-strobe channel ignores the address strobe alone
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b1, 1'b0, 4'd2);
    @(negedge clk);
    addr = 24'h100010; addrStrobe = 1'b1; dataStrobe = 1'b0;
    #1 check("R2 AS only chipSel", int'(chipSel), 0);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check("R2 AS only ack", int'(ackOut), 0);
    addrStrobe = 1'b0;
    access(24'h100010, 1, 4, "R2");

    // R3: synchronous-mode channel never selects
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b1, 4'd1);
    access(24'h100010, 0, 0, "R3");

    // R10: configuration agreement
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd5);
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd5);
    probe(24'h100020, "R10 same", 3, 0);
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd6);
    probe(24'h100020, "R10 ack differs", 3, 1);
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b1, 1'b0, 4'd5);
    probe(24'h100020, "R10 strobe differs", 3, 1);
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b1, 4'd5);
    probe(24'h100020, "R10 mode differs", 1, 1);

    // R9: shared counter, identical channels
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd5);
    access(24'h100020, 3, 7, "R9 shared");
    // R9: lowest index wins when fields differ
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd2);
    setCh(1, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd9);
    access(24'h100020, 3, 4, "R9 lowest");

    // R9: abort before acknowledge, then a fresh access
    setCh(1, 1'b0, 24'h0, 24'h0, 1'b0, 1'b0, 4'd0);
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd10);
    @(negedge clk);
    addr = 24'h100030; addrStrobe = 1'b1; dataStrobe = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    addrStrobe = 1'b0; dataStrobe = 1'b0;
    for (int k = 0; k < 14; k++) begin
      @(posedge clk); @(negedge clk);
      check("R9 abort", int'(ackOut), 0);
    end
    setCh(0, 1'b1, 24'h100000, 24'hFF0000, 1'b0, 1'b0, 4'd1);
    access(24'h100030, 1, 3, "R9 after abort");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule